// File: doc/BRIEF.md
# UART Interrupt and DMA Request Generator

This block sits beside a UART's receive and transmit data paths and turns their events into requests for the processor. It watches the occupancy counts of the receive and transmit queues, the strobes that move a character between a queue and its shifter, frame-error strobes, and a 16x baud tick. For each direction it raises either a one-cycle interrupt pulse or a DMA request level, depending on a per-direction mode. It tracks overrun and frame errors in sticky bits that clear on read, and it raises a single error pulse however many errors land in one cycle.

It works with queues that are DEPTH entries deep (FIFO mode) or with a single holding register (non-FIFO mode). In FIFO mode a receive queue that holds a few characters below its trigger level, with no traffic for three character times, raises a receive timeout request. The character time is set by the configured word length.

Top module: `uart_irq_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, every request output is 0 and stat_o is 0.
- R2: Mode fields rx_mode_i and tx_mode_i decode as 00 off, 01 interrupt, 10 DMA, and 11 as off. An event raises a one-cycle pulse on the interrupt output only in interrupt mode, and sets the DMA output only in DMA mode. Either response appears in the cycle after the event cycle.
- R3: In FIFO mode, a receive push when rx_count_i is below DEPTH is a receive event when rx_count_i+1 is at least the receive level. rx_trig_i values 0,1,2,3 select levels 0, DEPTH/4, DEPTH/2 and 3*DEPTH/4. Values 4 to 7 select DEPTH.
- R4: In non-FIFO mode, a receive push while rx_count_i is 0 is always a receive event.
- R5: A transmit pop is a transmit event in non-FIFO mode. In FIFO mode it is an event when rx-independent remainder tx_count_i-1 is at most the transmit level, which is decoded like R3 from tx_trig_i.
- R6: A DMA output, once set, stays high until its acknowledge input is high in a cycle with no new event of that direction. A new event wins over a same-cycle acknowledge.
- R7: In FIFO mode with the receive mode not off and 0 < rx_count_i < receive level, after 3*(7+word_len_i)*16 baud ticks with no push or pop, exactly one receive event occurs, on the last of those ticks. A push, a pop or leaving that condition restarts the count.
- R8: A receive push while the receive side is full (rx_count_i equal to DEPTH in FIFO mode, nonzero in non-FIFO mode) sets overrun bit stat_o[4] and is not a receive event.
- R9: A frame_err_i strobe sets frame bit stat_o[3] in the next cycle.
- R10: When err_irq_en_i is high, any cycle with a frame strobe or an overrun gives exactly one err_irq_o pulse in the next cycle, even when both errors occur together. With err_irq_en_i low there is no pulse, but the status bits are still set.
- R11: An err_rd_i strobe clears stat_o[4:3] in the next cycle. An error in the same cycle as the read keeps its bit set.
- R12: stat_o[2] is rx_count_i nonzero, stat_o[1] is tx_count_i zero and stat_o[0] is tx_shift_empty_i, each registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects queue mode, 0 selects the single holding register |
| rx_mode_i | input | 2 | Receive request mode |
| tx_mode_i | input | 2 | Transmit request mode |
| rx_trig_i | input | 3 | Receive level select |
| tx_trig_i | input | 3 | Transmit level select |
| word_len_i | input | 2 | Data bits minus 5 |
| err_irq_en_i | input | 1 | Error interrupt enable |
| baud_tick_i | input | 1 | 16x baud tick |
| rx_push_i | input | 1 | Receive shifter writes a character |
| rx_pop_i | input | 1 | Host reads a received character |
| rx_count_i | input | CNT_W | Receive occupancy before this cycle's push or pop |
| tx_pop_i | input | 1 | Transmit shifter takes a character |
| tx_count_i | input | CNT_W | Transmit occupancy before this cycle's pop |
| tx_shift_empty_i | input | 1 | Transmit shifter idle |
| frame_err_i | input | 1 | Frame error strobe |
| err_rd_i | input | 1 | Error status read strobe |
| rx_dma_ack_i | input | 1 | Receive DMA acknowledge |
| tx_dma_ack_i | input | 1 | Transmit DMA acknowledge |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| err_irq_o | output | 1 | Error interrupt pulse |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |
| stat_o | output | 5 | {overrun, frame, rx ready, tx empty, tx shifter empty} |

## Verification
A wrong level decode or compare shows as a missing or extra request pulse one cycle after the push or pop that crosses the level, so the bench sweeps every level select against every occupancy. A timeout counter that is off by one or restarts wrongly moves the single timeout pulse by one tick, or duplicates it. The bench therefore records the tick on which the pulse appears, for each word length. Sticky error bits that fail to hold or clear show on stat_o one cycle after the strobe or read. A lost DMA level shows in any cycle before its acknowledge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_IRQ = 2'b01,
    MODE_DMA = 2'b10,
    MODE_RSV = 2'b11
  } req_mode_e;

  // level select: 0..3 -> quarters of depth, 4..7 -> full depth
  function automatic logic [15:0] trig_level(input logic [2:0] sel, input logic [15:0] depth);
    logic [15:0] q;
    q = depth >> 2;
    case (sel)
      3'd0:    return '0;
      3'd1:    return q;
      3'd2:    return q << 1;
      3'd3:    return q * 16'd3;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_rx_path.sv
module uart_irq_rx_path
  import uart_irq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int CNT_W       = $clog2(DEPTH + 1),
  parameter int OVS         = 16,
  parameter int TO_CHARS    = 3,
  parameter int DATA_MIN    = 5,
  parameter int FRAME_EXTRA = 2,
  parameter int WL_W        = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             mode_on_i,
  input  logic [2:0]       trig_sel_i,
  input  logic [WL_W-1:0]  word_len_i,
  input  logic             baud_tick_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             req_o,
  output logic             overrun_o
);
  localparam int MAX_BITS  = DATA_MIN + FRAME_EXTRA + (1 << WL_W) - 1;
  localparam int MAX_LIMIT = TO_CHARS * MAX_BITS * OVS;
  localparam int TW        = $clog2(MAX_LIMIT + 1);

  logic [15:0]   lvl;
  logic          full, trig_hit, push_req;
  logic          to_arm, restart, fired, to_fire;
  logic [TW-1:0] to_cnt, limit_m1;

  assign lvl      = trig_level(trig_sel_i, 16'(DEPTH));
  assign full     = fifo_en_i ? (count_i == CNT_W'(DEPTH)) : (count_i != '0);
  assign trig_hit = !fifo_en_i || ((16'(count_i) + 16'd1) >= lvl);
  assign push_req = push_i && !full && trig_hit;

  // three character times, start + data + stop bits, OVS ticks per bit
  assign limit_m1 = TW'(TO_CHARS * OVS * (DATA_MIN + FRAME_EXTRA + int'(word_len_i)) - 1);

  assign to_arm  = fifo_en_i && mode_on_i && (count_i != '0) && (16'(count_i) < lvl);
  assign restart = !to_arm || push_i || pop_i;
  assign to_fire = !restart && baud_tick_i && !fired && (to_cnt == limit_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_cnt <= '0;
      fired  <= 1'b0;
    end else if (restart) begin
      to_cnt <= '0;
      fired  <= 1'b0;
    end else if (baud_tick_i && !fired) begin
      if (to_cnt == limit_m1) fired <= 1'b1;
      else                    to_cnt <= to_cnt + 1'b1;
    end
  end

  assign req_o     = push_req || to_fire;
  assign overrun_o = push_i && full;

endmodule

// File: rtl/uart_irq_tx_path.sv
module uart_irq_tx_path
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic [2:0]       trig_sel_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             req_o
);
  logic [15:0] lvl, remain;

  assign lvl    = trig_level(trig_sel_i, 16'(DEPTH));
  assign remain = (count_i == '0) ? 16'd0 : (16'(count_i) - 16'd1);
  assign req_o  = pop_i && (!fifo_en_i || (remain <= lvl));

endmodule

// File: rtl/uart_irq_req_out.sv
module uart_irq_req_out
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       req_i,
  input  logic       ack_i,
  output logic       irq_o,
  output logic       dma_o
);
  req_mode_e mode;
  assign mode = req_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      dma_o <= 1'b0;
    end else begin
      irq_o <= req_i && (mode == MODE_IRQ);
      if (req_i && (mode == MODE_DMA)) dma_o <= 1'b1;
      else if (ack_i)                  dma_o <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_err.sv
module uart_irq_err (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic       overrun_i,
  input  logic       rd_i,
  input  logic       irq_en_i,
  output logic [1:0] stat_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (overrun_i)  stat_o[1] <= 1'b1;
      else if (rd_i)  stat_o[1] <= 1'b0;
      if (frame_i)    stat_o[0] <= 1'b1;
      else if (rd_i)  stat_o[0] <= 1'b0;
      // simultaneous errors merge into one pulse
      irq_o <= irq_en_i && (frame_i || overrun_i);
    end
  end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int OVS      = 16,
  parameter int TO_CHARS = 3,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [1:0]       rx_mode_i,
  input  logic [1:0]       tx_mode_i,
  input  logic [2:0]       rx_trig_i,
  input  logic [2:0]       tx_trig_i,
  input  logic [1:0]       word_len_i,
  input  logic             err_irq_en_i,
  input  logic             baud_tick_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             tx_pop_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             tx_shift_empty_i,
  input  logic             frame_err_i,
  input  logic             err_rd_i,
  input  logic             rx_dma_ack_i,
  input  logic             tx_dma_ack_i,
  output logic             rx_irq_o,
  output logic             tx_irq_o,
  output logic             err_irq_o,
  output logic             rx_dma_o,
  output logic             tx_dma_o,
  output logic [4:0]       stat_o
);
  localparam int NDIR = 2;

  logic            rx_req, tx_req, overrun, rx_on;
  logic [1:0]      err_stat;
  logic [2:0]      flags_q;
  logic [NDIR-1:0] dir_req, dir_ack, dir_irq, dir_dma;
  logic [1:0]      dir_mode [NDIR];

  assign rx_on = (req_mode_e'(rx_mode_i) == MODE_IRQ) || (req_mode_e'(rx_mode_i) == MODE_DMA);

  uart_irq_rx_path #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .OVS(OVS), .TO_CHARS(TO_CHARS),
    .DATA_MIN(5), .FRAME_EXTRA(2), .WL_W(2)
  ) u_rx (
    .clk_i, .rst_ni, .fifo_en_i,
    .mode_on_i   (rx_on),
    .trig_sel_i  (rx_trig_i),
    .word_len_i  (word_len_i),
    .baud_tick_i (baud_tick_i),
    .push_i      (rx_push_i),
    .pop_i       (rx_pop_i),
    .count_i     (rx_count_i),
    .req_o       (rx_req),
    .overrun_o   (overrun)
  );

  uart_irq_tx_path #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
    .fifo_en_i,
    .trig_sel_i (tx_trig_i),
    .pop_i      (tx_pop_i),
    .count_i    (tx_count_i),
    .req_o      (tx_req)
  );

  assign dir_req     = {tx_req, rx_req};
  assign dir_ack     = {tx_dma_ack_i, rx_dma_ack_i};
  assign dir_mode[0] = rx_mode_i;
  assign dir_mode[1] = tx_mode_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    uart_irq_req_out u_out (
      .clk_i, .rst_ni,
      .mode_i (dir_mode[d]),
      .req_i  (dir_req[d]),
      .ack_i  (dir_ack[d]),
      .irq_o  (dir_irq[d]),
      .dma_o  (dir_dma[d])
    );
  end

  assign rx_irq_o = dir_irq[0];
  assign tx_irq_o = dir_irq[1];
  assign rx_dma_o = dir_dma[0];
  assign tx_dma_o = dir_dma[1];

  uart_irq_err u_err (
    .clk_i, .rst_ni,
    .frame_i   (frame_err_i),
    .overrun_i (overrun),
    .rd_i      (err_rd_i),
    .irq_en_i  (err_irq_en_i),
    .stat_o    (err_stat),
    .irq_o     (err_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= {rx_count_i != '0, tx_count_i == '0, tx_shift_empty_i};
  end

  assign stat_o = {err_stat, flags_q};

endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk
  import uart_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic [1:0]       rx_mode_i,
  input logic [1:0]       tx_mode_i,
  input logic             err_irq_en_i,
  input logic             rx_push_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic             tx_pop_i,
  input logic             err_rd_i,
  input logic             rx_dma_ack_i,
  input logic             tx_dma_ack_i,
  input logic             rx_irq_o,
  input logic             tx_irq_o,
  input logic             err_irq_o,
  input logic             rx_dma_o,
  input logic             tx_dma_o,
  input logic [4:0]       stat_o
);
  p_rx_irq_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> ($past(rx_mode_i) == MODE_IRQ));
  p_tx_irq_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> ($past(tx_mode_i) == MODE_IRQ));
  p_nofifo_rx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && rx_push_i && rx_count_i == '0 && rx_mode_i == MODE_IRQ) |=> rx_irq_o);
  p_nofifo_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && tx_pop_i && tx_mode_i == MODE_IRQ) |=> tx_irq_o);
  p_rx_dma_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dma_o && !rx_dma_ack_i) |=> rx_dma_o);
  p_tx_dma_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dma_o && !tx_dma_ack_i) |=> tx_dma_o);
  p_overrun_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_push_i && rx_count_i == CNT_W'(DEPTH)) |=> stat_o[4]);
  p_err_irq_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> $past(err_irq_en_i));
  p_err_irq_stat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (stat_o[4] || stat_o[3]));
  p_ovr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[4] && !err_rd_i) |=> stat_o[4]);
  p_frm_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[3] && !err_rd_i) |=> stat_o[3]);
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_uart_irq_gen.sv
module sim_uart_irq_gen;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fifo_en_i, err_irq_en_i, baud_tick_i, rx_push_i, rx_pop_i, tx_pop_i;
  logic tx_shift_empty_i, frame_err_i, err_rd_i, rx_dma_ack_i, tx_dma_ack_i;
  logic [1:0] rx_mode_i, tx_mode_i, word_len_i;
  logic [2:0] rx_trig_i, tx_trig_i;
  logic [CW-1:0] rx_count_i, tx_count_i;
  logic rx_irq_o, tx_irq_o, err_irq_o, rx_dma_o, tx_dma_o;
  logic [4:0] stat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_irq_gen #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input int sel);
    return (sel >= 4) ? DEPTH : sel * (DEPTH / 4);
  endfunction

  task automatic strobes_off();
    baud_tick_i = 0; rx_push_i = 0; rx_pop_i = 0; tx_pop_i = 0;
    frame_err_i = 0; err_rd_i = 0; rx_dma_ack_i = 0; tx_dma_ack_i = 0;
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int first, pulses, lim;
    strobes_off();
    fifo_en_i = 1; err_irq_en_i = 1; rx_mode_i = 2'b01; tx_mode_i = 2'b01;
    rx_trig_i = 0; tx_trig_i = 0; word_len_i = 0; rx_count_i = 0; tx_count_i = 0;
    tx_shift_empty_i = 1;
    cyc(); cyc();
    chk("R1 reset outputs", {rx_irq_o, tx_irq_o, err_irq_o, rx_dma_o, tx_dma_o}, 0);
    chk("R1 reset stat", stat_o, 0);
    rst_ni = 1;
    rx_mode_i = 2'b00; tx_mode_i = 2'b00; tx_count_i = 1; tx_shift_empty_i = 0;
    cyc();
    chk("R1 first cycle", {rx_irq_o, tx_irq_o, err_irq_o, rx_dma_o, tx_dma_o}, 0);

    // R3 sweep: every level select against every non-full count
    rx_mode_i = 2'b01; fifo_en_i = 1;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < DEPTH; c++) begin
        rx_trig_i = 3'(s); rx_count_i = CW'(c); rx_push_i = 1;
        cyc(); rx_push_i = 0;
        chk($sformatf("R3 sel=%0d cnt=%0d", s, c), rx_irq_o, (c + 1 >= lvl_of(s)) ? 1 : 0);
      end

    // R5 sweep FIFO and non-FIFO
    tx_mode_i = 2'b01;
    for (int s = 0; s < 8; s++)
      for (int c = 1; c <= DEPTH; c++) begin
        tx_trig_i = 3'(s); tx_count_i = CW'(c); tx_pop_i = 1;
        cyc(); tx_pop_i = 0;
        chk($sformatf("R5 sel=%0d cnt=%0d", s, c), tx_irq_o, (c - 1 <= lvl_of(s)) ? 1 : 0);
      end
    fifo_en_i = 0; tx_trig_i = 0;
    for (int c = 1; c <= DEPTH; c += 5) begin
      tx_count_i = CW'(c); tx_pop_i = 1;
      cyc(); tx_pop_i = 0;
      chk("R5 non-FIFO pop", tx_irq_o, 1);
    end

    // R2 / R4 mode decode in non-FIFO mode
    rx_count_i = 0;
    for (int m = 0; m < 4; m++) begin
      rx_mode_i = 2'(m); rx_push_i = 1;
      cyc(); rx_push_i = 0;
      chk($sformatf("R2 R4 irq mode=%0d", m), rx_irq_o, (m == 1) ? 1 : 0);
      chk($sformatf("R2 dma mode=%0d", m), rx_dma_o, (m == 2) ? 1 : 0);
      cyc();
      chk("R2 irq one cycle", rx_irq_o, 0);
      rx_dma_ack_i = 1; cyc(); rx_dma_ack_i = 0;
    end

    // R6 DMA hold and ack priority
    tx_mode_i = 2'b10; tx_pop_i = 1; cyc(); tx_pop_i = 0;
    cyc(); cyc(); cyc();
    chk("R6 dma held", tx_dma_o, 1);
    chk("R2 no irq in dma mode", tx_irq_o, 0);
    tx_pop_i = 1; tx_dma_ack_i = 1; cyc(); tx_pop_i = 0; tx_dma_ack_i = 0;
    chk("R6 event beats ack", tx_dma_o, 1);
    tx_dma_ack_i = 1; cyc(); tx_dma_ack_i = 0;
    chk("R6 ack clears", tx_dma_o, 0);

    // R8 overrun non-FIFO and FIFO
    rx_mode_i = 2'b01; err_irq_en_i = 1;
    rx_count_i = 1; rx_push_i = 1; cyc(); rx_push_i = 0;
    chk("R8 non-FIFO overrun no rx irq", rx_irq_o, 0);
    chk("R8 non-FIFO overrun bit", stat_o[4], 1);
    chk("R10 overrun pulse", err_irq_o, 1);
    cyc();
    chk("R10 single pulse", err_irq_o, 0);
    err_rd_i = 1; cyc(); err_rd_i = 0;
    chk("R11 read clears", stat_o[4:3], 0);
    fifo_en_i = 1; rx_trig_i = 0; rx_count_i = CW'(DEPTH); rx_push_i = 1; cyc(); rx_push_i = 0;
    chk("R8 FIFO overrun no rx irq", rx_irq_o, 0);
    chk("R8 FIFO overrun bit", stat_o[4], 1);

    // R9/R10 both errors together, one pulse
    err_rd_i = 1; cyc(); err_rd_i = 0;
    rx_count_i = CW'(DEPTH); rx_push_i = 1; frame_err_i = 1; cyc(); rx_push_i = 0; frame_err_i = 0;
    chk("R9 frame bit", stat_o[3], 1);
    chk("R10 both errors one pulse", err_irq_o, 1);
    cyc();
    chk("R10 pulse ends", err_irq_o, 0);
    chk("R9 R8 bits held", stat_o[4:3], 3);
    err_rd_i = 1; frame_err_i = 1; cyc(); err_rd_i = 0; frame_err_i = 0;
    chk("R11 frame wins over read", stat_o[4:3], 1);
    err_rd_i = 1; cyc(); err_rd_i = 0;
    err_irq_en_i = 0; frame_err_i = 1; cyc(); frame_err_i = 0;
    chk("R10 disabled no pulse", err_irq_o, 0);
    chk("R9 bit set while disabled", stat_o[3], 1);
    err_rd_i = 1; cyc(); err_rd_i = 0;

    // R12 status flags, all eight combinations
    for (int k = 0; k < 8; k++) begin
      rx_count_i = k[2] ? CW'(5) : CW'(0);
      tx_count_i = k[1] ? CW'(0) : CW'(3);
      tx_shift_empty_i = k[0];
      cyc();
      chk($sformatf("R12 flags k=%0d", k), stat_o[2:0], k);
    end

    // R7 receive timeout per word length
    fifo_en_i = 1; rx_mode_i = 2'b01; rx_trig_i = 3'd2;
    for (int w = 0; w < 4; w++) begin
      lim = 3 * (7 + w) * 16;
      word_len_i = 2'(w); rx_count_i = 0; cyc();
      rx_count_i = 3; cyc();
      for (int pass = 0; pass < 2; pass++) begin
        first = -1; pulses = 0;
        for (int i = 0; i < lim + 20; i++) begin
          baud_tick_i = 1; cyc(); baud_tick_i = 0;
          if (rx_irq_o) begin pulses++; if (first < 0) first = i; end
        end
        chk($sformatf("R7 wl=%0d pass=%0d tick", w, pass), first, lim - 1);
        chk($sformatf("R7 wl=%0d pass=%0d count", w, pass), pulses, 1);
        rx_pop_i = 1; cyc(); rx_pop_i = 0;
      end
    end
    // no timeout at or above level, nor in non-FIFO mode
    word_len_i = 0; lim = 3 * 7 * 16;
    for (int v = 0; v < 2; v++) begin
      fifo_en_i = (v == 1) ? 1'b0 : 1'b1;
      rx_count_i = (v == 0) ? CW'(lvl_of(2)) : CW'(1);
      pulses = 0;
      for (int i = 0; i < lim + 10; i++) begin
        baud_tick_i = 1; cyc(); baud_tick_i = 0;
        if (rx_irq_o) pulses++;
      end
      chk($sformatf("R7 no timeout case %0d", v), pulses, 0);
    end

    finish_run();
  end
endmodule